// File: doc/BRIEF.md
# Synchronous Memory Read Master

This block runs read transfers from a CPU-side request to a clocked memory bus whose control strobes are active low. It runs on a phase clock at twice the bus rate. Each phase clock cycle is one half of a bus clock cycle. The block generates the bus clock itself, so it can place the address, the strobes and the data capture on exact half-cycle boundaries. A basic read takes three bus cycles, named T1, T2 and T3. The memory can stretch a read by pulling the wait input low. Each stretch adds one whole bus cycle that repeats the T2 shape.

The CPU side holds `req` high with an address until a phase clock edge where `busy` is low. The request is taken at that edge. The read word arrives on `rdata` during a one-phase `done` pulse. `rdata` then holds that value until the next read captures a new word.

Top module: `mem_read_master`

## Requirements
- R1: A synchronous active-low reset leaves `mreq_n` and `rd_n` high, `done` low, `rdata` zero, `bus_addr` zero and `bus_clk` low.
- R2: `bus_clk` inverts on every phase clock edge out of reset, so each bus clock half equals one phase clock period.
- R3: The request address appears on `bus_addr` in the first phase after acceptance. It stays unchanged through the low phase of T3. Outside a transfer `bus_addr` is zero.
- R4: `mreq_n` and `rd_n` fall together in the low phase of T1, one phase after the address first appears.
- R5: `wait_n` is sampled at the end of the T2 low phase and at the end of each wait low phase. When it is 0 there, one extra bus cycle is inserted in which the address and the strobes do not change.
- R6: `bus_data` is captured only at the edge that ends the high phase of T3. Values presented in other phases are not captured.
- R7: `done` is 1 for exactly the low phase of T3, with the captured word on `rdata`. `rdata` keeps that word after `done` falls.
- R8: `mreq_n` and `rd_n` rise together after the T3 low phase, and the bus returns to idle.
- R9: `busy` is 1 from the first phase of T1 through the T3 low phase, and also in any idle phase where `bus_clk` is high. A request raised while `busy` is 1 is ignored.
- R10: T1 always begins with `bus_clk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Phase clock, twice the bus rate |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Read request, taken at an edge where busy is 0 |
| req_addr | input | ADDR_W | Address of the requested word |
| busy | output | 1 | Request cannot be taken this phase |
| done | output | 1 | One-phase pulse, rdata is valid |
| rdata | output | DATA_W | Captured read word (buffer register) |
| bus_clk | output | 1 | Generated bus clock |
| bus_addr | output | ADDR_W | Bus address lines |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wait_n | input | 1 | Wait request from memory, active low |
| bus_data | input | DATA_W | Read data from memory |

## Verification
The memory model in the bench puts valid data on the bus only during the high phase of T3 and drives a junk value at all other times. A design that captures a phase early or a phase late therefore returns the junk value. Reads are run with zero, one and three wait cycles. A master that ignores `wait_n`, or samples it in the wrong phase, raises `done` at the wrong phase. A request injected in the middle of a transfer with a different address catches a master that would take it: its address would change or a new strobe would appear after `done`. Each phase is checked for the strobes and the address, which catches strobes asserted together with the address instead of one phase later.

// File: rtl/mem_read_master.sv
module mem_read_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_clk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              mreq_n,
  output logic              rd_n,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] bus_data
);
  typedef enum logic [3:0] {
    P_IDLE, P_T1H, P_T1L, P_T2H, P_T2L, P_TWH, P_TWL, P_T3H, P_T3L
  } phase_t;

  phase_t            ph, ph_nx;
  logic [ADDR_W-1:0] addr_q;
  logic              in_cycle, strobe_on, accept;

  assign in_cycle  = (ph != P_IDLE);
  assign strobe_on = in_cycle && (ph != P_T1H);
  assign busy      = in_cycle || bus_clk;
  assign accept    = req && !busy;
  assign bus_addr  = in_cycle ? addr_q : '0;
  assign mreq_n    = !strobe_on;
  assign rd_n      = !strobe_on;
  assign done      = (ph == P_T3L);

  always_comb begin
    ph_nx = ph;
    case (ph)
      P_IDLE:  if (accept) ph_nx = P_T1H;
      P_T1H:   ph_nx = P_T1L;
      P_T1L:   ph_nx = P_T2H;
      P_T2H:   ph_nx = P_T2L;
      P_T2L:   ph_nx = wait_n ? P_T3H : P_TWH;
      P_TWH:   ph_nx = P_TWL;
      P_TWL:   ph_nx = wait_n ? P_T3H : P_TWH;
      P_T3H:   ph_nx = P_T3L;
      P_T3L:   ph_nx = P_IDLE;
      default: ph_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      bus_clk <= 1'b0;
      addr_q  <= '0;
      rdata   <= '0;
    end else begin
      ph      <= ph_nx;
      bus_clk <= !bus_clk;
      if (accept) addr_q <= req_addr;
      if (ph == P_T3H) rdata <= bus_data;
    end
  end
endmodule

// File: rtl/mem_read_master_chk.sv
module mem_read_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk2x,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic              bus_clk,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              wait_n
);
  logic armed;
  always_ff @(posedge clk2x) armed <= rst_n;

  // R2
  bclk_toggle_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    bus_clk != $past(bus_clk));

  // R4
  strobe_after_addr_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    $fell(mreq_n) |-> ($fell(rd_n) && !bus_clk && $stable(bus_addr) && bus_addr == bus_addr));

  // R5
  wait_hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    (!mreq_n && !bus_clk && !wait_n && !done) |=> (!mreq_n && $stable(bus_addr) && !done) ##1 !done);

  // R6
  capture_only_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    !$stable(rdata) |-> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    done |=> (!done && mreq_n));

  // R8
  release_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    $rose(mreq_n) |-> ($rose(rd_n) && bus_addr == '0));

  // R9
  busy_cover_chk: assert property (@(posedge clk2x) disable iff (!rst_n || !armed)
    !mreq_n |-> busy);
endmodule

bind mem_read_master mem_read_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .busy(busy), .done(done), .rdata(rdata),
  .bus_clk(bus_clk), .bus_addr(bus_addr), .mreq_n(mreq_n), .rd_n(rd_n), .wait_n(wait_n)
);

// File: tb/test_mem_read_master.sv
module test_mem_read_master;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] JUNK = 16'hDEAD;

  logic          clk2x = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, done, bus_clk, mreq_n, rd_n, wait_n;
  logic [DW-1:0] rdata, bus_data;
  logic [AW-1:0] bus_addr;

  int n_chk = 0;
  int n_bad = 0;
  int nwait = 0;
  int hcnt = 0;
  logic prev_clk = 1'b0;

  always #10 clk2x = ~clk2x;

  mem_read_master #(.ADDR_W(AW), .DATA_W(DW)) i_mem_read_master (
    .clk2x(clk2x), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .busy(busy), .done(done), .rdata(rdata), .bus_clk(bus_clk),
    .bus_addr(bus_addr), .mreq_n(mreq_n), .rd_n(rd_n),
    .wait_n(wait_n), .bus_data(bus_data)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a * 16'd3) ^ 16'h5A3C;
  endfunction

  // responder: counts bus clock high phases while strobes are low
  always @(negedge clk2x) begin
    if (mreq_n) hcnt <= 0;
    else if (bus_clk && !prev_clk) hcnt <= hcnt + 1;
    prev_clk <= bus_clk;
  end
  assign wait_n   = !(!mreq_n && !bus_clk && hcnt >= 1 && hcnt <= nwait);
  assign bus_data = (!mreq_n && !rd_n && bus_clk && hcnt == nwait + 2) ? mem_word(bus_addr) : JUNK;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk2x);
    chk(mreq_n && rd_n, "R1 strobes high", {mreq_n, rd_n}, 2'b11);
    chk(rdata == '0, "R1 rdata clear", rdata, 0);
    chk(!done && bus_addr == '0 && !bus_clk, "R1 idle outputs", {done, bus_clk, bus_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk2x);
    chk(bus_clk, "R2 bus clock toggles", bus_clk, 1);
    @(negedge clk2x);
    chk(!bus_clk, "R2 bus clock toggles", bus_clk, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int w, input bit intrude);
    nwait = w;
    while (busy) @(negedge clk2x);
    req = 1'b1; req_addr = a;
    @(negedge clk2x);
    req = 1'b0; req_addr = ~a;
    chk(bus_clk, "R10 T1 starts high", bus_clk, 1);
    chk(bus_addr == a, "R3 address in T1 high", bus_addr, a);
    chk(mreq_n && rd_n, "R4 strobes still high in T1 high", {mreq_n, rd_n}, 2'b11);
    chk(busy, "R9 busy in T1", busy, 1);
    @(negedge clk2x);
    chk(!mreq_n && !rd_n && !bus_clk, "R4 strobes low in T1 low", {bus_clk, mreq_n, rd_n}, 0);
    if (intrude) begin req = 1'b1; req_addr = a ^ 16'h00FF; end
    @(negedge clk2x);
    req = 1'b0;
    chk(busy && !mreq_n && bus_addr == a, "R9 T2 high busy, address held", bus_addr, a);
    @(negedge clk2x);
    chk(!done && bus_addr == a, "R3 T2 low address held", bus_addr, a);
    for (int i = 0; i < 2 * w; i++) begin
      @(negedge clk2x);
      chk(!done && !mreq_n && !rd_n && bus_addr == a, "R5 wait phase holds",
          {done, mreq_n, rd_n, bus_addr}, {3'b000, a});
    end
    @(negedge clk2x);
    chk(bus_clk && !done && !mreq_n, "R5 T3 high after waits", {bus_clk, done}, 2'b10);
    @(negedge clk2x);
    chk(done, "R7 done in T3 low", done, 1);
    chk(rdata == mem_word(a), "R6 captured word", rdata, mem_word(a));
    chk(bus_addr == a && !mreq_n, "R3 address held in T3 low", bus_addr, a);
    @(negedge clk2x);
    chk(mreq_n && rd_n, "R8 strobes released", {mreq_n, rd_n}, 2'b11);
    chk(!done && bus_addr == '0, "R8 idle bus", {done, bus_addr}, 0);
    chk(rdata == mem_word(a), "R7 rdata held", rdata, mem_word(a));
    if (intrude) begin
      repeat (4) begin
        @(negedge clk2x);
        chk(mreq_n && bus_addr == '0, "R9 request while busy ignored", {mreq_n, bus_addr}, {1'b1, 16'h0});
      end
    end
  endtask

  task automatic busy_idle_test();
    while (!(bus_clk == 1'b1 && mreq_n)) @(negedge clk2x);
    chk(busy, "R9 busy when idle with bus clock high", busy, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    reset_test();
    do_read(16'h1234, 0, 1'b0);
    do_read(16'hBEEF, 1, 1'b0);
    do_read(16'h0042, 3, 1'b1);
    busy_idle_test();
    do_read(16'hFFFF, 0, 1'b1);
    do_read(16'h0000, 2, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule